// File: doc/BRIEF.md
# RS485 Reply Frame Sender with Driver-Enable Control

This block transmits a reply frame that another part of the chip has already assembled in a byte buffer. The frame leaves over a half-duplex RS485 link, through a UART serializer (8 data bits, no parity, 1 stop bit, 9600 baud) that sits outside this block. A one-cycle start pulse and a body length begin a transmission. The block first reads the whole body from the buffer and runs it through a bit-serial CRC-16 engine, one bit per clock. It then streams the body bytes and the two CRC bytes to the serializer over a valid/ready handshake.

The transceiver driver-enable line goes high as soon as a start is accepted, well before the first byte reaches the serializer. It stays high until the serializer reports that the stop bit of the final byte has left the line. The block counts per-byte completion events from the serializer for this; the moment the last byte is handed off does not count. A level "busy" flag tells the receive path to discard bytes, such as the echo of its own transmission, for the whole time the bus is held. A done pulse marks the moment the bus is released.

The buffer is read through a synchronous port: the address is registered and data returns one clock later, which suits inferred block RAM.

Top module: `rs485_reply_tx`

## Requirements
- R1: After reset, de_o, busy_o, tx_valid_o and done_o are all 0.
- R2: de_o and busy_o go high at the clock edge that accepts start_i. This is always before tx_valid_o first rises, and tx_valid_o is never high while de_o is low.
- R3: The CRC starts at 0xFFFF. For each body byte, the byte is XORed into bits 7:0, then the register shifts right 8 times, and 0xA001 is XORed in after each shift whose outgoing bit was 1. For the ASCII body "123456789" the CRC is 0x4B37.
- R4: The handed-off byte sequence is body bytes from buffer addresses 0 to frame_len_i-1 in order, then CRC bits 7:0, then CRC bits 15:8, for frame_len_i+2 handoffs in total.
- R5: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o stays unchanged.
- R6: de_o and busy_o stay high until the number of tx_cmpl_i pulses counted since the start equals frame_len_i+2. They fall at the clock edge that samples the pulse reaching that count, and done_o is high for exactly the one cycle after that edge.
- R7: A start_i pulse while busy_o is high is ignored. The frame in flight keeps its length and byte sequence, and no second frame follows.
- R8: A body length of 0 sends only the CRC seed, bytes 0xFF then 0xFF.
- R9: For a body of L >= 1 bytes, the CRC pass takes 10 cycles per byte. tx_valid_o first rises at the edge 10*L+2 clock edges after the edge that accepts start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send a frame |
| frame_len_i | input | $clog2(MAX_LEN+1) | Body length in bytes, sampled with start_i |
| buf_addr_o | output | $clog2(MAX_LEN) | Buffer read address (registered) |
| buf_data_i | input | 8 | Buffer read data, one cycle after the address |
| tx_data_o | output | 8 | Byte offered to the UART serializer |
| tx_valid_o | output | 1 | tx_data_o is valid |
| tx_ready_i | input | 1 | Serializer accepts the byte this cycle |
| tx_cmpl_i | input | 1 | Serializer pulse: a byte's stop bit has finished |
| de_o | output | 1 | Transceiver driver enable |
| busy_o | output | 1 | Transmitting flag; receive path discards input while high |
| done_o | output | 1 | One-cycle pulse when the bus is released |

## Verification
The main function is tried with several kinds of body:
- The standard nine-byte check string, which pins the CRC against a known value.
- A six-byte body of mixed bit patterns, which separates correct reflection and byte order from a swapped or unreflected CRC.
- An empty body, which exposes any error in the seed.

The handshake is stalled for several cycles on every byte to tell a held byte from a dropped or changed one. Completion pulses are withheld one short of the total, so that releasing the driver at the last handoff is told apart from releasing it at the last stop bit. A start issued mid-frame, and the exact count of clock edges before the first byte, separate proper ignoring and the bit-serial CRC timing from a restarted or shortened pass.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'hA001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CRC_ADDR,
    ST_CRC_LOAD,
    ST_CRC_BIT,
    ST_BODY_ADDR,
    ST_BODY_LOAD,
    ST_TAIL,
    ST_HOLD,
    ST_DRAIN
  } tx_state_e;

endpackage

// File: rtl/rs485_crc16_serial.sv
module rs485_crc16_serial
  import rs485_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init_i,
  input  logic        load_i,
  input  logic [7:0]  data_i,
  input  logic        step_i,
  output logic [15:0] crc_o
);

  logic [15:0] crc_q;
  logic [7:0]  shreg_q;
  logic        fb;

  // feedback bit: outgoing CRC bit combined with the next data bit (LSB first)
  assign fb = crc_q[0] ^ shreg_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q   <= CRC_SEED;
      shreg_q <= '0;
    end else if (init_i) begin
      crc_q   <= CRC_SEED;
    end else if (load_i) begin
      shreg_q <= data_i;
    end else if (step_i) begin
      crc_q   <= (crc_q >> 1) ^ (fb ? CRC_POLY : 16'h0000);
      shreg_q <= shreg_q >> 1;
    end
  end

  assign crc_o = crc_q;

  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (crc_o == CRC_SEED)); // R3

  AST_CRC_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    !(load_i && step_i) && !(init_i && step_i)); // R3

endmodule

// File: rtl/rs485_drain_tracker.sv
module rs485_drain_tracker #(
  parameter int MAX_LEN = 128,
  localparam int CNT_W = $clog2(MAX_LEN + 3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             count_en_i,
  input  logic             cmpl_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             drained_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc   = cnt_q + CNT_W'(cmpl_i);
  assign drained_o = count_en_i && (cnt_inc >= total_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (count_en_i && cmpl_i && (cnt_q < total_i)) begin
      cnt_q <= cnt_inc;
    end
  end

  AST_CMPL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_en_i |-> (cnt_q <= total_i)); // R6

endmodule

// File: rtl/rs485_tx_ctrl.sv
module rs485_tx_ctrl
  import rs485_tx_pkg::*;
#(
  parameter int MAX_LEN = 128,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int ADDR_W = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_data_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [15:0]       crc_i,
  output logic              crc_init_o,
  output logic              crc_load_o,
  output logic              crc_step_o,
  output logic              cnt_clear_o,
  output logic [CNT_W-1:0]  total_o,
  input  logic              drained_i,
  output logic              de_o,
  output logic              busy_o,
  output logic              done_o
);

  tx_state_e        state_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;
  logic [CNT_W-1:0] sent_q;
  logic [2:0]       bit_q;
  logic [CNT_W-1:0] len_ext;
  logic [CNT_W-1:0] sent_nxt;
  logic             accept;
  logic             last_body_crc;

  assign accept        = (state_q == ST_IDLE) && start_i;
  assign len_ext       = CNT_W'(len_q);
  assign sent_nxt      = sent_q + CNT_W'(1);
  assign last_body_crc = ((idx_q + LEN_W'(1)) == len_q);

  assign crc_init_o  = accept;
  assign crc_load_o  = (state_q == ST_CRC_LOAD);
  assign crc_step_o  = (state_q == ST_CRC_BIT);
  assign cnt_clear_o = accept;
  assign total_o     = len_ext + CNT_W'(2);
  assign buf_addr_o  = idx_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      len_q      <= '0;
      idx_q      <= '0;
      sent_q     <= '0;
      bit_q      <= '0;
      tx_data_o  <= '0;
      tx_valid_o <= 1'b0;
      de_o       <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            len_q   <= frame_len_i;
            idx_q   <= '0;
            sent_q  <= '0;
            de_o    <= 1'b1;
            busy_o  <= 1'b1;
            state_q <= (frame_len_i == '0) ? ST_TAIL : ST_CRC_ADDR;
          end
        end
        ST_CRC_ADDR: state_q <= ST_CRC_LOAD;
        ST_CRC_LOAD: begin
          bit_q   <= '0;
          state_q <= ST_CRC_BIT;
        end
        ST_CRC_BIT: begin
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            if (last_body_crc) begin
              idx_q   <= '0;
              state_q <= ST_BODY_ADDR;
            end else begin
              idx_q   <= idx_q + LEN_W'(1);
              state_q <= ST_CRC_ADDR;
            end
          end
        end
        ST_BODY_ADDR: state_q <= ST_BODY_LOAD;
        ST_BODY_LOAD: begin
          tx_data_o  <= buf_data_i;
          tx_valid_o <= 1'b1;
          state_q    <= ST_HOLD;
        end
        ST_TAIL: begin
          tx_data_o  <= (sent_q == len_ext) ? crc_i[7:0] : crc_i[15:8];
          tx_valid_o <= 1'b1;
          state_q    <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tx_ready_i) begin
            tx_valid_o <= 1'b0;
            sent_q     <= sent_nxt;
            if (sent_nxt == total_o) begin
              state_q <= ST_DRAIN;
            end else if (sent_nxt < len_ext) begin
              idx_q   <= idx_q + LEN_W'(1);
              state_q <= ST_BODY_ADDR;
            end else begin
              state_q <= ST_TAIL;
            end
          end
        end
        ST_DRAIN: begin
          if (drained_i) begin
            de_o    <= 1'b0;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_VALID_NEEDS_DE: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> de_o); // R2

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R5

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!de_o && !busy_o && $past(de_o))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_LEN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(len_q)); // R7

endmodule

// File: rtl/rs485_reply_tx.sv
module rs485_reply_tx #(
  parameter int MAX_LEN = 128,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int ADDR_W = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_data_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic              tx_cmpl_i,
  output logic              de_o,
  output logic              busy_o,
  output logic              done_o
);

  logic [15:0]      crc;
  logic             crc_init;
  logic             crc_load;
  logic             crc_step;
  logic             cnt_clear;
  logic [CNT_W-1:0] total;
  logic             drained;

  rs485_crc16_serial u_crc (
    .clk    (clk),
    .rst    (rst),
    .init_i (crc_init),
    .load_i (crc_load),
    .data_i (buf_data_i),
    .step_i (crc_step),
    .crc_o  (crc)
  );

  rs485_drain_tracker #(.MAX_LEN(MAX_LEN)) u_drain (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (cnt_clear),
    .count_en_i (busy_o),
    .cmpl_i     (tx_cmpl_i),
    .total_i    (total),
    .drained_o  (drained)
  );

  rs485_tx_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .frame_len_i (frame_len_i),
    .buf_addr_o  (buf_addr_o),
    .buf_data_i  (buf_data_i),
    .tx_data_o   (tx_data_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .crc_i       (crc),
    .crc_init_o  (crc_init),
    .crc_load_o  (crc_load),
    .crc_step_o  (crc_step),
    .cnt_clear_o (cnt_clear),
    .total_o     (total),
    .drained_i   (drained),
    .de_o        (de_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

endmodule

// File: tb/rs485_reply_tx_tb.sv
module rs485_reply_tx_tb_top;

  localparam int MAX_LEN = 128;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int ADDR_W  = $clog2(MAX_LEN);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [LEN_W-1:0]  frame_len_i = '0;
  logic [ADDR_W-1:0] buf_addr_o;
  logic [7:0]        buf_data_i;
  logic [7:0]        tx_data_o;
  logic              tx_valid_o;
  logic              tx_ready_i = 1'b0;
  logic              tx_cmpl_i = 1'b0;
  logic              de_o;
  logic              busy_o;
  logic              done_o;

  logic [7:0] mem [0:MAX_LEN-1];
  logic [7:0] got [0:MAX_LEN+1];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) buf_data_i <= mem[buf_addr_o];

  rs485_reply_tx #(.MAX_LEN(MAX_LEN)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .frame_len_i(frame_len_i),
    .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .tx_cmpl_i(tx_cmpl_i), .de_o(de_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int len);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {8'h00, mem[i]};
      for (int b = 0; b < 8; b++) begin
        if (c[0]) c = (c >> 1) ^ 16'hA001;
        else      c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic pulse_start(input int len);
    @(negedge clk);
    frame_len_i = LEN_W'(len);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Receive one byte; optional stall of three cycles checks R5.
  task automatic get_byte(input bit stall, output logic [7:0] b, output bit ok);
    int w;
    logic [7:0] d0;
    w = 0;
    ok = 1'b0;
    b = '0;
    while (!tx_valid_o && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (!tx_valid_o) return;
    chk(de_o == 1'b1, "R2 de during valid", int'(de_o), 1);
    if (stall) begin
      d0 = tx_data_o;
      repeat (3) @(negedge clk);
      chk(tx_valid_o && tx_data_o == d0, "R5 held under stall", int'(tx_data_o), int'(d0));
    end
    b = tx_data_o;
    tx_ready_i = 1'b1;
    @(posedge clk);
    #1 tx_ready_i = 1'b0;
    ok = 1'b1;
  endtask

  task automatic cmpl_pulse();
    @(negedge clk);
    tx_cmpl_i = 1'b1;
    @(negedge clk);
    tx_cmpl_i = 1'b0;
  endtask

  // Receive a full frame and check it; then release with completion pulses.
  task automatic recv_and_release(input int len, input bit stall, input string tag);
    bit ok;
    logic [7:0] b;
    logic [15:0] c;
    int n;
    c = ref_crc(len);
    n = 0;
    for (int i = 0; i < len + 2; i++) begin
      get_byte(stall, b, ok);
      if (!ok) break;
      got[i] = b;
      n++;
    end
    chk(n == len + 2, {tag, " R4 byte count"}, n, len + 2);
    for (int i = 0; i < len && i < n; i++)
      chk(got[i] == mem[i], {tag, " R4 body byte"}, int'(got[i]), int'(mem[i]));
    if (n == len + 2) begin
      chk(got[len] == c[7:0], {tag, " R3 crc low"}, int'(got[len]), int'(c[7:0]));
      chk(got[len+1] == c[15:8], {tag, " R3 crc high"}, int'(got[len+1]), int'(c[15:8]));
    end
    for (int i = 0; i < len + 1; i++) cmpl_pulse();
    chk(de_o && busy_o, {tag, " R6 held until last stop bit"}, int'(de_o), 1);
    cmpl_pulse();
    chk(!de_o && !busy_o, {tag, " R6 released"}, int'(de_o), 0);
    chk(done_o == 1'b1, {tag, " R6 done pulse"}, int'(done_o), 1);
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " R6 done single cycle"}, int'(done_o), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!de_o && !busy_o && !tx_valid_o && !done_o, "R1 reset outputs",
        int'({de_o, busy_o, tx_valid_o, done_o}), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_check_string();
    string s = "123456789";
    for (int i = 0; i < 9; i++) mem[i] = s[i];
    chk(ref_crc(9) == 16'h4B37, "R3 model check value", int'(ref_crc(9)), 16'h4B37);
    pulse_start(9);
    recv_and_release(9, 1'b0, "ascii");
  endtask

  task automatic t_mixed_stall();
    mem[0] = 8'h11; mem[1] = 8'h03; mem[2] = 8'h00;
    mem[3] = 8'h6B; mem[4] = 8'hFF; mem[5] = 8'h80;
    pulse_start(6);
    recv_and_release(6, 1'b1, "stall");
  endtask

  task automatic t_empty();
    pulse_start(0);
    chk(de_o && busy_o, "R2 empty body de on accept", int'(de_o), 1);
    recv_and_release(0, 1'b0, "R8 empty");
  endtask

  task automatic t_latency();
    int n;
    mem[0] = 8'hA5; mem[1] = 8'h5A; mem[2] = 8'h3C;
    pulse_start(3);
    n = 1;
    chk(de_o && busy_o && !tx_valid_o, "R2 de before first byte", int'(de_o), 1);
    while (!tx_valid_o && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(n == 33, "R9 first byte latency", n, 33);
    recv_and_release(3, 1'b0, "lat");
  endtask

  task automatic t_start_busy();
    bit ok;
    logic [7:0] b;
    logic [15:0] c;
    int extra;
    for (int i = 0; i < 4; i++) mem[i] = 8'(8'h20 + i);
    c = ref_crc(4);
    pulse_start(4);
    get_byte(1'b0, b, ok);
    chk(ok && b == mem[0], "R7 first byte", int'(b), int'(mem[0]));
    pulse_start(1);
    for (int i = 1; i < 6; i++) begin
      get_byte(1'b0, b, ok);
      got[i] = b;
    end
    chk(got[3] == mem[3], "R7 body unchanged", int'(got[3]), int'(mem[3]));
    chk(got[4] == c[7:0] && got[5] == c[15:8], "R7 crc unchanged",
        int'({got[5], got[4]}), int'(c));
    repeat (6) cmpl_pulse();
    chk(!de_o && done_o, "R7 released after own frame", int'(de_o), 0);
    extra = 0;
    repeat (60) begin
      @(negedge clk);
      if (tx_valid_o || de_o) extra++;
    end
    chk(extra == 0, "R7 no second frame", extra, 0);
  endtask

  initial begin
    for (int i = 0; i < MAX_LEN; i++) mem[i] = '0;
    t_reset();
    t_check_string();
    t_mixed_stall();
    t_empty();
    t_latency();
    t_start_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule